// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture Unit

This block timestamps external events against a free-running 16-bit timer. One up-counter runs while the unit is both enabled and started. When it reaches its top value it rolls over to zero and keeps counting. Two capture channels, A and B, each watch one event pin. A selected transition on a pin copies the live count into that channel's capture register and raises the channel's capture flag. Software can subtract two stored counts to measure an event period or a pulse width.

Each event pin passes through a two-stage synchronizer. An edge is found by comparing the synchronized level with its previous sample. A per-channel two-bit selector picks which transitions count. If a new capture lands while the channel's capture flag is still pending, the register takes the newer value and a sticky overrun flag records that a result was lost. All flags are write-one-to-clear. A single interrupt line combines the flags through per-flag enables.

Software reaches the unit through a small word-wide register bus. Reads are combinational; writes take effect on the clock edge.

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | flags | read, write-one-to-clear |
| 2 | capture A | read-only |
| 3 | capture B | read-only |
| 4 | counter | read/write |
| 5 to 7 | unused | read as zero |

Top module: `tcu_top`

## Requirements
- R1: While control bit 0 (enable) and control bit 1 (run) are both 1, the counter increases by one on every clock, and rolls over from 0xFFFF to 0x0000.
- R2: When either enable or run is 0, the counter holds its value. A bus write to address 4 loads the counter with the written data, and this load wins over counting.
- R3: Control bits [3:2] select the trigger for channel A and bits [5:4] for channel B. Code 0 disables capture, 1 selects rising edges, 2 selects falling edges and 3 selects both.
- R4: On a qualifying edge, the capture register receives the counter value present two clock edges after the pin changed. That is the counter reading at the moment of the change plus two. Capture A reads at address 2 and capture B at address 3.
- R5: The capture flag of the channel is set on the same edge that stores the capture. Flags read at address 1, with bit 0 for A and bit 1 for B.
- R6: A capture that arrives while the channel's capture flag is already set still replaces the register contents. It also sets the channel's overrun flag, which is bit 2 for A and bit 3 for B at address 1.
- R7: Pin edges that arrive while enable or run is 0 leave the flags and capture registers unchanged.
- R8: Writing 1 to a flag bit at address 1 clears it, and writing 0 leaves it alone. When a hardware set and a software clear meet on the same edge, the flag ends up set.
- R9: The irq output is high when any flag is set together with its enable. Control bit 8 enables the A capture flag, bit 9 the B capture flag, bit 10 the A overrun flag and bit 11 the B overrun flag.
- R10: After reset the counter, both capture registers, all flags and the control register read as zero, and irq is low.
- R11: The two channels are independent: an edge on one pin never changes the other channel's flags or capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counter, synchronizers and registers |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 2 | Asynchronous event pins, bit 0 is channel A, bit 1 is channel B |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, acted on at the clock edge |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter and a two-stage synchronizer. With two stages, the capture latency is exactly two counts, so every stored value can be predicted from one counter read taken just before the pin changes. Preloading the counter through address 4 brings the 0xFFFF-to-0x0000 rollover within a few clocks. Because the bus write path is single-cycle, a flag clear can be placed on exactly the edge where a capture lands.

// File: rtl/tcu_pkg.sv
// Package tcu_pkg
// Shared encodings for the timer capture unit: the trigger-select code,
// the register address map and the control-register bit positions.
// Assumes exactly two capture channels (A = index 0, B = index 1).
package tcu_pkg;

    localparam int N_CH = 2;

    typedef enum logic [1:0] {
        TRG_OFF  = 2'd0,
        TRG_RISE = 2'd1,
        TRG_FALL = 2'd2,
        TRG_BOTH = 2'd3
    } trig_e;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_FLAGS = 3'd1;
    localparam logic [2:0] ADR_CAPA  = 3'd2;
    localparam logic [2:0] ADR_CAPB  = 3'd3;
    localparam logic [2:0] ADR_CNT   = 3'd4;

    localparam int BIT_EN     = 0;
    localparam int BIT_RUN    = 1;
    localparam int TRG_LSB    = 2;
    localparam int IE_CAP_LSB = 8;
    localparam int IE_OVR_LSB = IE_CAP_LSB + N_CH;
    localparam int CTRL_BITS  = IE_OVR_LSB + N_CH;

endpackage

// File: rtl/tcu_counter.sv
// Module tcu_counter
// Free-running up-counter with rollover. It advances by one per clock
// while run_i is high and holds otherwise. A load request replaces the
// value and wins over counting.
// Assumes run_i and load_i are synchronous to clk.
module tcu_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Counter register: reset, load, increment (natural rollover) or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tcu_edge_sync.sv
// Module tcu_edge_sync
// Brings one asynchronous event pin into the clock domain through a
// STAGES-deep flop chain. It then flags a rising and/or falling
// transition, as the trigger code selects, for exactly one cycle.
// Assumes each pin level lasts longer than one clock period.
module tcu_edge_sync
    import tcu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  trig_e trig_i,
    output logic  hit_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic              fall;

    // First synchronizer stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_i;
    end

    // Remaining synchronizer stages, one flop per extra stage.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // Previous synchronized level, used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Edge classification and trigger qualification.
    always_comb begin
        rise  = sync_q[STAGES-1] & ~prev_q;
        fall  = ~sync_q[STAGES-1] & prev_q;
        hit_o = (trig_i[0] & rise) | (trig_i[1] & fall);
    end

endmodule

// File: rtl/tcu_capture_chan.sv
// Module tcu_capture_chan
// One capture channel: the stored count, the capture flag and the
// sticky overrun flag. A hit stores the count and sets the capture
// flag. A hit that finds the flag already set also sets the overrun
// flag. The clear inputs are single-cycle; a hit on the same edge wins.
// Assumes hit_i is already qualified by the counter running.
module tcu_capture_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_cap_i,
    input  logic             clr_ovr_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             cap_flag_o,
    output logic             ovr_flag_o
);

    logic [CNT_W-1:0] cap_q;
    logic             cap_flag_q;
    logic             ovr_flag_q;

    // Capture register: loads the live count on a qualified hit.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_q <= '0;
        else if (hit_i) cap_q <= cnt_i;
    end

    // Flags: hardware set has priority over the write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_flag_q <= 1'b0;
            ovr_flag_q <= 1'b0;
        end else begin
            cap_flag_q <= hit_i | (cap_flag_q & ~clr_cap_i);
            ovr_flag_q <= (hit_i & cap_flag_q) | (ovr_flag_q & ~clr_ovr_i);
        end
    end

    assign cap_o      = cap_q;
    assign cap_flag_o = cap_flag_q;
    assign ovr_flag_o = ovr_flag_q;

endmodule

// File: rtl/tcu_top.sv
// Module tcu_top
// Dual-channel input-capture timer. It holds the control register,
// decodes the register bus, gates edge hits with the run state and
// combines the flags into one interrupt line.
// Assumes a single clock and bus writes that are one cycle wide.
module tcu_top
    import tcu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  evt_i,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             bus_we,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CTRL_MASK = CNT_W'((1 << CTRL_BITS) - 1);

    logic [CNT_W-1:0]             ctrl_q;
    logic                         running;
    logic                         cnt_load;
    logic                         flag_wr;
    logic [CNT_W-1:0]             cnt_q;
    logic [N_CH-1:0]              raw_hit;
    logic [N_CH-1:0]              hit;
    logic [N_CH-1:0]              cap_flag;
    logic [N_CH-1:0]              ovr_flag;
    logic [N_CH-1:0][CNT_W-1:0]   cap_val;

    // Control register: written whole, unused bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (bus_we && bus_addr == ADR_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    // Bus write decode and run qualification.
    always_comb begin
        running  = ctrl_q[BIT_EN] & ctrl_q[BIT_RUN];
        cnt_load = bus_we && (bus_addr == ADR_CNT);
        flag_wr  = bus_we && (bus_addr == ADR_FLAGS);
    end

    tcu_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (running),
        .load_i    (cnt_load),
        .load_val_i(bus_wdata),
        .cnt_o     (cnt_q)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tcu_edge_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (evt_i[i]),
            .trig_i(trig_e'(ctrl_q[TRG_LSB + 2*i +: 2])),
            .hit_o (raw_hit[i])
        );

        assign hit[i] = raw_hit[i] & running;

        tcu_capture_chan #(
            .CNT_W(CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit[i]),
            .cnt_i     (cnt_q),
            .clr_cap_i (flag_wr & bus_wdata[i]),
            .clr_ovr_i (flag_wr & bus_wdata[N_CH + i]),
            .cap_o     (cap_val[i]),
            .cap_flag_o(cap_flag[i]),
            .ovr_flag_o(ovr_flag[i])
        );
    end

    // Read multiplexer for the register bus.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL:  bus_rdata = ctrl_q;
            ADR_FLAGS: bus_rdata = CNT_W'({ovr_flag, cap_flag});
            ADR_CAPA:  bus_rdata = cap_val[0];
            ADR_CAPB:  bus_rdata = cap_val[1];
            ADR_CNT:   bus_rdata = cnt_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Interrupt combine: each flag gated by its own enable.
    always_comb begin
        irq = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            irq = irq | (cap_flag[i] & ctrl_q[IE_CAP_LSB + i])
                      | (ovr_flag[i] & ctrl_q[IE_OVR_LSB + i]);
        end
    end

endmodule

// File: rtl/tcu_checker.sv
// Module tcu_checker
// Temporal checks for tcu_top, attached with bind. It watches the
// counter, the qualified hits and each channel's stored count and flags.
module tcu_checker
    import tcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       running,
    input logic                       cnt_load,
    input logic [CNT_W-1:0]           cnt_q,
    input logic [N_CH-1:0]            hit,
    input logic [N_CH-1:0]            cap_flag,
    input logic [N_CH-1:0]            ovr_flag,
    input logic [N_CH-1:0][CNT_W-1:0] cap_val
);

    // R1: the count advances by one (with rollover) while running.
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cnt_load) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R2: the count holds while stopped and not loaded.
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_load) |=> $stable(cnt_q));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R4: the stored value is the count seen on the capturing edge.
        a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> cap_val[i] == $past(cnt_q));

        // R5: a capture leaves the channel flag set.
        a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> cap_flag[i]);

        // R6: capturing over a pending flag raises the overrun flag.
        a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && cap_flag[i]) |=> ovr_flag[i]);

        // R7: nothing is stored while the counter is stopped.
        a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !running |=> $stable(cap_val[i]));

        // R8: a flag only rises on a capture.
        a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cap_flag[i]) |-> $past(hit[i]));
    end

endmodule

bind tcu_top tcu_checker #(
    .CNT_W(CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .cnt_load(cnt_load),
    .cnt_q   (cnt_q),
    .hit     (hit),
    .cap_flag(cap_flag),
    .ovr_flag(ovr_flag),
    .cap_val (cap_val)
);

// File: tb/tcu_top_tb.sv
`timescale 1ns/1ps
module tcu_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  evt = 2'b00;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic        we = 1'b0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [15:0] RUN_EN = 16'h0003;

    // Vector fields: {channel, trigger code, level before, level after, capture expected}
    localparam logic [5:0] VEC [16] = '{
        6'b0_00_01_0, 6'b0_00_10_0, 6'b0_01_01_1, 6'b0_01_10_0,
        6'b0_10_01_0, 6'b0_10_10_1, 6'b0_11_01_1, 6'b0_11_10_1,
        6'b1_00_01_0, 6'b1_00_10_0, 6'b1_01_01_1, 6'b1_01_10_0,
        6'b1_10_01_0, 6'b1_10_10_1, 6'b1_11_01_1, 6'b1_11_10_1
    };

    always #2.5 clk = ~clk;

    tcu_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .bus_addr (addr),
        .bus_wdata(wdata),
        .bus_we   (we),
        .bus_rdata(rdata),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v, c0, c1, prev_cap;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        bus_read(3'd0, v); check("R10 ctrl", v, 16'h0);
        bus_read(3'd1, v); check("R10 flags", v, 16'h0);
        bus_read(3'd2, v); check("R10 capA", v, 16'h0);
        bus_read(3'd3, v); check("R10 capB", v, 16'h0);
        bus_read(3'd4, v); check("R10 count", v, 16'h0);
        check("R10 irq", {15'h0, irq}, 16'h0);

        // R3 R4 R5 R7: vector table over trigger codes and both channels
        for (int k = 0; k < 16; k++) begin
            logic       ch, lv0, lv1, ex;
            logic [1:0] tr;
            {ch, tr, lv0, lv1, ex} = VEC[k];
            bus_write(3'd0, RUN_EN);
            evt[ch] = lv0;
            wait_n(4);
            bus_write(3'd1, 16'h000F);
            bus_write(3'd0, RUN_EN | (16'(tr) << (2 + 2*ch)));
            bus_read(3'd2 + 3'(ch), prev_cap);
            bus_read(3'd4, c0);
            evt[ch] = lv1;
            wait_n(4);
            bus_read(3'd1, v);
            check("R3 R5 flag per trigger code", {15'h0, v[ch]}, {15'h0, ex});
            bus_read(3'd2 + 3'(ch), v);
            if (ex) check("R4 captured count", v, c0 + 16'd2);
            else    check("R3 R7 capture untouched", v, prev_cap);
        end

        // R1 R2: preload, rollover, hold
        bus_write(3'd0, RUN_EN);
        bus_write(3'd4, 16'hFFFE);
        bus_read(3'd4, v); check("R2 load", v, 16'hFFFE);
        wait_n(1); bus_read(3'd4, v); check("R1 step", v, 16'hFFFF);
        wait_n(1); bus_read(3'd4, v); check("R1 rollover", v, 16'h0000);
        bus_write(3'd0, 16'h0001);
        bus_read(3'd4, c0);
        wait_n(3); bus_read(3'd4, v); check("R2 hold when run low", v, c0);

        // R7: edges ignored when enable low (run high) with both-edge trigger
        bus_write(3'd0, 16'h0002 | 16'h000C);
        bus_write(3'd1, 16'h000F);
        bus_read(3'd2, prev_cap);
        evt[0] = ~evt[0]; wait_n(4); evt[0] = ~evt[0]; wait_n(4);
        bus_read(3'd1, v); check("R7 no flag when stopped", v, 16'h0);
        bus_read(3'd2, v); check("R7 capture held when stopped", v, prev_cap);

        // R6: overrun on second rising edge with flag pending
        evt = 2'b00;
        bus_write(3'd0, RUN_EN | 16'h0004);
        wait_n(4);
        bus_write(3'd1, 16'h000F);
        evt[0] = 1'b1; wait_n(4);
        bus_read(3'd1, v); check("R6 first capture no overrun", v, 16'h0001);
        evt[0] = 1'b0; wait_n(4);
        bus_read(3'd4, c1);
        evt[0] = 1'b1; wait_n(4);
        bus_read(3'd1, v); check("R6 overrun set", v, 16'h0005);
        bus_read(3'd2, v); check("R6 newer count stored", v, c1 + 16'd2);

        // R9: interrupt gating with A capture and overrun pending
        check("R9 irq off without enables", {15'h0, irq}, 16'h0);
        bus_write(3'd0, RUN_EN | 16'h0004 | 16'h0100);
        check("R9 irq via capture enable", {15'h0, irq}, 16'h1);
        bus_write(3'd0, RUN_EN | 16'h0004 | 16'h0400);
        check("R9 irq via overrun enable", {15'h0, irq}, 16'h1);
        bus_write(3'd0, RUN_EN | 16'h0004 | 16'h0200 | 16'h0800);
        check("R9 irq off with B enables only", {15'h0, irq}, 16'h0);

        // R8: write-one-to-clear behaviour
        bus_write(3'd1, 16'h0000);
        bus_read(3'd1, v); check("R8 zero write no effect", v, 16'h0005);
        bus_write(3'd1, 16'h0001);
        bus_read(3'd1, v); check("R8 clear capture only", v, 16'h0004);
        bus_write(3'd1, 16'h0004);
        bus_read(3'd1, v); check("R8 clear overrun", v, 16'h0000);

        // R8: set wins over a clear on the same edge
        bus_write(3'd0, RUN_EN | 16'h0004);
        evt[0] = 1'b0; wait_n(4);
        bus_write(3'd1, 16'h000F);
        evt[0] = 1'b1;
        wait_n(2);
        addr = 3'd1; wdata = 16'h0001; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        bus_read(3'd1, v); check("R8 set beats clear", v, 16'h0001);

        // R11: channel B edge does not disturb channel A
        bus_write(3'd0, RUN_EN | 16'h003C);
        wait_n(4);
        bus_write(3'd1, 16'h000F);
        bus_read(3'd2, prev_cap);
        evt[1] = ~evt[1]; wait_n(4);
        bus_read(3'd1, v); check("R11 only B flag", v, 16'h0002);
        bus_read(3'd2, v); check("R11 capA unchanged", v, prev_cap);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule